// File: doc/BRIEF.md
# Linear N/96 Inset Decimator

This block shrinks a live video stream for a picture-in-picture inset. It thins out samples along each line and whole lines within each field. The ratio is any whole number N over a fixed denominator of 96, so the kept fraction changes in steps of 1/96 rather than in powers of two. Two phase accumulators make the keep-or-drop decisions. The horizontal accumulator advances on every incoming sample of a kept line. The vertical accumulator advances on every line start. Whenever a running sum reaches 96, one item is kept and 96 is taken off the sum. A ratio of zero switches the inset off.

Each kept sample can pass through unchanged. It can also be replaced by the rounded mean of itself and the sample just before it on the same line, which acts as a two-tap anti-alias filter. The decimated stream leaves one cycle after the kept sample enters, with a valid strobe. Writing to memory is left to the block downstream.

Top module: `inset_decimator`

## Requirements
- R1: While reset is asserted and after its release, until a sample is kept, `pixOutValid` is 0 and `pixOut` is 0.
- R2: With horizontal ratio H (1 to 48), zero-based sample k of a kept line is output exactly when floor((k+1)·H/96) > floor(k·H/96). A 1408-sample line at H = 48 therefore gives 704 outputs, which are the odd-indexed samples.
- R3: Reduction is linear. H = 24 turns a 1408-sample line into 352 outputs, and idle cycles between samples do not change which samples are kept.
- R4: `hRatio` = 0 produces no output samples.
- R5: `hRatio` values above 48 act exactly as 48.
- R6: With vertical ratio V (1 to 96), zero-based line j of a field is kept exactly when floor((j+1)·V/96) > floor(j·V/96). A 228-line field keeps 228·V/96 lines, rounded down: 228 at V = 96, 57 at 24, 38 at 16 and 28 at 12.
- R7: `vRatio` = 0 produces no output, and `vRatio` values above 96 act exactly as 96.
- R8: `lineStart` resets the horizontal phase, even in the middle of a line. A sample presented in the same cycle as `lineStart` is sample 0 of the new line.
- R9: `fieldStart` resets the vertical phase. When it coincides with `lineStart`, that line is line 0 of the new field.
- R10: With `avgEn` = 0, a kept sample appears unchanged on `pixOut`, and `pixOutValid` is high in the cycle right after the sample was presented. It is low in every other cycle.
- R11: With `avgEn` = 1, the output is (cur + prev + 1) >> 1, where prev is the previous valid sample of the same line. Sample 0 of a line passes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pixIn | input | 8 | Incoming sample |
| pixValid | input | 1 | `pixIn` carries a sample this cycle |
| lineStart | input | 1 | A new line begins this cycle |
| fieldStart | input | 1 | A new field begins this cycle |
| hRatio | input | 6 | Horizontal ratio N of N/96; 0 = off; above 48 clamped |
| vRatio | input | 7 | Vertical ratio N of N/96; 0 = off; above 96 clamped |
| avgEn | input | 1 | 1 = output the two-tap mean instead of the raw sample |
| pixOut | output | 8 | Decimated sample |
| pixOutValid | output | 1 | `pixOut` holds a new sample this cycle |

## Verification
Some events fall in the same cycle. A line restart can coincide with the line's first sample. It can also cut a line short while the horizontal remainder is non-zero. A field restart can coincide with a line restart. In these cases the reset must win over the old remainder, and the new decision must apply to the sample or line that arrives in that very cycle. The bench runs lines in both framings: a separate restart cycle, and a restart merged with the first sample. It deliberately stops lines and fields early at ratios of 36/96, where a carried remainder would shift the kept positions. A scoreboard then judges each output value, and the cycle it appears in, against a per-index keep formula that starts afresh on every line and field.

// File: rtl/inset_decim_pkg.sv
package inset_decim_pkg;

  // Per-cycle commands from the phase control to the sample datapath.
  typedef struct packed {
    logic take;     // current input sample is kept
    logic restart;  // a new line begins this cycle
  } decim_strobe_t;

endpackage

// File: rtl/inset_decim_ctrl.sv
module inset_decim_ctrl
  import inset_decim_pkg::*;
#(
  parameter int H_W   = 6,
  parameter int V_W   = 7,
  parameter int DEN   = 96,
  parameter int H_MAX = 48,
  parameter int V_MAX = 96
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pixValid,
  input  logic              lineStart,
  input  logic              fieldStart,
  input  logic [H_W-1:0]    hRatio,
  input  logic [V_W-1:0]    vRatio,
  output decim_strobe_t     strobe
);

  localparam int ACC_W = $clog2(2 * DEN);
  localparam logic [ACC_W-1:0] DEN_C  = ACC_W'(DEN);
  localparam logic [ACC_W-1:0] HMAX_C = ACC_W'(H_MAX);
  localparam logic [ACC_W-1:0] VMAX_C = ACC_W'(V_MAX);

  logic [ACC_W-1:0] hN, vN;
  logic [ACC_W-1:0] hAcc, vAcc;
  logic [ACC_W-1:0] hBase, vBase, hSum, vSum;
  logic             hHit, vHit, lineKeep, lineOn;

  // Clamp the programmed ratios to their legal maxima.
  always_comb begin
    hN = (ACC_W'(hRatio) > HMAX_C) ? HMAX_C : ACC_W'(hRatio);
    vN = (ACC_W'(vRatio) > VMAX_C) ? VMAX_C : ACC_W'(vRatio);
  end

  // Vertical phase: evaluated once per line start.
  always_comb begin
    vBase = fieldStart ? '0 : vAcc;
    vSum  = vBase + vN;
    vHit  = (vSum >= DEN_C);
  end

  assign lineOn = lineStart ? vHit : lineKeep;

  // Horizontal phase: evaluated on each sample of a kept line.
  always_comb begin
    hBase = lineStart ? '0 : hAcc;
    hSum  = hBase + hN;
    hHit  = (hSum >= DEN_C);
  end

  always_comb begin
    strobe.take    = pixValid && lineOn && hHit;
    strobe.restart = lineStart;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vAcc     <= '0;
      lineKeep <= 1'b0;
    end else if (lineStart) begin
      lineKeep <= vHit;
      vAcc     <= vHit ? (vSum - DEN_C) : vSum;
    end else if (fieldStart) begin
      lineKeep <= 1'b0;
      vAcc     <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hAcc <= '0;
    end else if (pixValid && lineOn) begin
      hAcc <= hHit ? (hSum - DEN_C) : hSum;
    end else if (lineStart) begin
      hAcc <= '0;
    end
  end

  // R2
  hacc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hAcc < DEN_C);

  // R6
  vacc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vAcc < DEN_C);

  // R4
  hzero_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hRatio == '0) |-> !strobe.take);

  // R7
  vzero_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lineStart && vRatio == '0) |=> !lineKeep);

  // R8
  hphase_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lineStart && !pixValid) |=> (hAcc == '0));

  // R9
  vphase_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fieldStart && !lineStart) |=> (vAcc == '0));

endmodule

// File: rtl/inset_decim_dpath.sv
module inset_decim_dpath
  import inset_decim_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] pixIn,
  input  logic              pixValid,
  input  logic              avgEn,
  input  decim_strobe_t     strobe,
  output logic [DATA_W-1:0] pixOut,
  output logic              pixOutValid
);

  logic [DATA_W-1:0] prevPix, outVal;
  logic [DATA_W:0]   pairSum;
  logic              havePrev, usePrev;

  always_comb begin
    usePrev = havePrev && !strobe.restart;
    pairSum = {1'b0, pixIn} + {1'b0, prevPix} + (DATA_W+1)'(1);
    outVal  = (avgEn && usePrev) ? pairSum[DATA_W:1] : pixIn;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prevPix  <= '0;
      havePrev <= 1'b0;
    end else if (pixValid) begin
      prevPix  <= pixIn;
      havePrev <= 1'b1;
    end else if (strobe.restart) begin
      havePrev <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pixOut      <= '0;
      pixOutValid <= 1'b0;
    end else begin
      pixOutValid <= strobe.take;
      if (strobe.take) pixOut <= outVal;
    end
  end

  // R10
  out_needs_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pixOutValid |-> $past(pixValid));

  // R11
  avg_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pixOutValid |->
      ((pixOut >= $past(pixIn)) || (pixOut >= $past(prevPix))) &&
      ((pixOut <= $past(pixIn)) || (pixOut <= $past(prevPix))));

endmodule

// File: rtl/inset_decimator.sv
module inset_decimator
  import inset_decim_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int H_W    = 6,
  parameter int V_W    = 7,
  parameter int DEN    = 96,
  parameter int H_MAX  = 48,
  parameter int V_MAX  = 96
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] pixIn,
  input  logic              pixValid,
  input  logic              lineStart,
  input  logic              fieldStart,
  input  logic [H_W-1:0]    hRatio,
  input  logic [V_W-1:0]    vRatio,
  input  logic              avgEn,
  output logic [DATA_W-1:0] pixOut,
  output logic              pixOutValid
);

  decim_strobe_t strobe;

  inset_decim_ctrl #(
    .H_W(H_W), .V_W(V_W), .DEN(DEN), .H_MAX(H_MAX), .V_MAX(V_MAX)
  ) i_ctrl (
    .clk(clk), .rst_n(rst_n), .pixValid(pixValid), .lineStart(lineStart),
    .fieldStart(fieldStart), .hRatio(hRatio), .vRatio(vRatio), .strobe(strobe)
  );

  inset_decim_dpath #(
    .DATA_W(DATA_W)
  ) i_dpath (
    .clk(clk), .rst_n(rst_n), .pixIn(pixIn), .pixValid(pixValid),
    .avgEn(avgEn), .strobe(strobe), .pixOut(pixOut), .pixOutValid(pixOutValid)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!pixOutValid && pixOut == '0));

endmodule

// File: tb/test_inset_decimator.sv
module test_inset_decimator;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] pixIn;
  logic       pixValid, lineStart, fieldStart, avgEn;
  logic [5:0] hRatio;
  logic [6:0] vRatio;
  logic [7:0] pixOut;
  logic       pixOutValid;

  int checks = 0;
  int failures = 0;
  int gotCount = 0;
  string curTag = "R1";
  logic [7:0] expQ[$];
  logic takeFlag = 1'b0;
  logic takeDly = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  inset_decimator i_inset_decimator (
    .clk(clk), .rst_n(rst_n), .pixIn(pixIn), .pixValid(pixValid),
    .lineStart(lineStart), .fieldStart(fieldStart), .hRatio(hRatio),
    .vRatio(vRatio), .avgEn(avgEn), .pixOut(pixOut), .pixOutValid(pixOutValid)
  );

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // Expected output cycle: one clock after the kept sample is presented (R10).
  always @(posedge clk) takeDly <= takeFlag;

  // Monitor: compares every output against the scoreboard queue.
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (pixOutValid === 1'b1 || takeDly) begin
        checks++;
        if (pixOutValid !== takeDly) begin
          failures++;
          $display("FAIL R10 timing (%s): valid %0b expected %0b", curTag, pixOutValid, takeDly);
        end
      end
      if (pixOutValid === 1'b1) begin
        gotCount++;
        checks++;
        if (expQ.size() == 0) begin
          failures++;
          $display("FAIL %s: unexpected sample %0d expected none", curTag, pixOut);
        end else begin
          logic [7:0] e;
          e = expQ.pop_front();
          if (pixOut !== e) begin
            failures++;
            $display("FAIL %s: pixOut %0d expected %0d", curTag, pixOut, e);
          end
        end
      end
    end
  end

  function automatic int clampI(input int v, input int mx);
    return (v > mx) ? mx : v;
  endfunction

  // Driver: drives one field and pushes expected samples. Called at a negedge.
  task automatic drive_field(input int hR, input int vR, input int lines,
                             input int samples, input bit together,
                             input bit fieldWithLine, input bit avg,
                             input bit gaps, input int seed);
    int hN, vN;
    hN = clampI(hR, 48);
    vN = clampI(vR, 96);
    hRatio = 6'(hR);
    vRatio = 7'(vR);
    avgEn  = avg;
    if (!fieldWithLine) begin
      fieldStart = 1'b1;
      @(negedge clk);
      fieldStart = 1'b0;
    end
    for (int j = 0; j < lines; j++) begin
      bit kept, fs;
      logic [7:0] prev;
      kept = ((j + 1) * vN) / 96 > (j * vN) / 96;
      fs = (j == 0) && fieldWithLine;
      prev = 8'h00;
      if (!together) begin
        lineStart = 1'b1;
        fieldStart = fs;
        pixValid = 1'b0;
        @(negedge clk);
        lineStart = 1'b0;
        fieldStart = 1'b0;
      end
      for (int k = 0; k < samples; k++) begin
        logic [7:0] p;
        if (gaps && (k % 3 == 2)) begin
          pixValid = 1'b0;
          takeFlag = 1'b0;
          @(negedge clk);
        end
        p = 8'((j * 37 + k * 13 + seed) & 255);
        pixIn = p;
        pixValid = 1'b1;
        if (together && k == 0) begin
          lineStart = 1'b1;
          fieldStart = fs;
        end
        takeFlag = 1'b0;
        if (kept && (((k + 1) * hN) / 96 > (k * hN) / 96)) begin
          logic [8:0] s;
          s = {1'b0, p} + {1'b0, prev} + 9'd1;
          expQ.push_back((avg && k != 0) ? s[8:1] : p);
          takeFlag = 1'b1;
        end
        prev = p;
        @(negedge clk);
        lineStart = 1'b0;
        fieldStart = 1'b0;
        pixValid = 1'b0;
        takeFlag = 1'b0;
      end
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic run(input string tag, input int hR, input int vR,
                     input int lines, input int samples, input bit together,
                     input bit fieldWithLine, input bit avg, input bit gaps,
                     input int expCount);
    curTag = tag;
    gotCount = 0;
    drive_field(hR, vR, lines, samples, together, fieldWithLine, avg, gaps, lines + samples);
    check({tag, " output count"}, gotCount, expCount);
    check({tag, " scoreboard drained"}, expQ.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    pixIn = '0; pixValid = 0; lineStart = 0; fieldStart = 0;
    hRatio = 6'd48; vRatio = 7'd96; avgEn = 0;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", int'(pixOutValid), 0);
    check("R1 data in reset", int'(pixOut), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", int'(pixOutValid), 0);

    run("R2 H48 full line",      48, 96, 2, 1408, 0, 0, 0, 0, 1408);
    run("R3 H24 linear gaps",    24, 96, 1, 1408, 0, 0, 0, 1, 352);
    run("R4 H0 off",              0, 96, 2,   40, 0, 0, 0, 0, 0);
    run("R5 H63 clamp",          63, 96, 1, 1408, 0, 0, 0, 0, 704);
    run("R6 V96 field",          48, 96, 228,  8, 0, 0, 0, 0, 912);
    run("R6 V24 replay",         48, 24, 228,  4, 0, 0, 0, 0, 114);
    run("R6 V16 replay",         48, 16, 228,  4, 0, 0, 0, 0, 76);
    run("R6 V12 H12 replay",     12, 12, 228, 16, 0, 0, 0, 0, 56);
    run("R7 V0 off",             48,  0, 3,    8, 0, 0, 0, 0, 0);
    run("R7 V127 clamp",         48, 127, 4,   8, 0, 0, 0, 0, 16);
    run("R8 short lines H36",    36, 96, 4,    5, 0, 0, 0, 0, 4);
    run("R8 merged restart H36", 36, 96, 4,    5, 1, 0, 0, 0, 4);
    run("R8 merged restart H48", 48, 96, 2,   10, 1, 0, 0, 0, 10);
    run("R9 V36 merged field",   48, 36, 3,    4, 0, 1, 0, 0, 2);
    run("R9 V36 merged again",   48, 36, 3,    4, 1, 1, 0, 0, 2);
    run("R9 V36 separate field", 48, 36, 3,    4, 0, 0, 0, 0, 2);
    run("R10 raw pass H48",      48, 96, 1,   12, 0, 0, 0, 1, 6);
    run("R11 average H36 gaps",  36, 96, 2,   12, 0, 0, 1, 1, 8);
    run("R11 average merged",    48, 96, 1,    6, 1, 0, 1, 0, 3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule